// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches three ports of eight input pins each and turns selected pin conditions into interrupt requests. Every pin has its own settings: level or edge sensing, which level or edge counts as active, an enable, and an optional filter that ignores short pulses. Pin values arrive already synchronised to the block clock. A simple register bus sets these options, reads back a per-port status byte, and acknowledges edge events by writing ones to an acknowledge register.

Ports A and B share one combined request line. Port F drives eight separate request lines, one for each pin, so each of those pins can go to its own vector. All state resets to zero. After reset every pin is level-sensitive, active-low and disabled, and no request is raised.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every configuration register reads 0, every status register reads 0, `irq_ab` is 0 and `irq_f` is 0.
- R2: Register addresses. Port A: mode 0x90, polarity 0x94, acknowledge 0x98, enable 0x9C, filter 0xA8, status 0xA0. Port B: 0xAC, 0xB0, 0xB4, 0xB8, 0xC4, status 0xBC. Port F: 0x4C, 0x50, 0x54, 0x58, 0x64, status 0x5C. Mode, polarity, enable and filter read back the value written. The acknowledge register reads 0. A write to a status address changes nothing.
- R3: In level mode (mode bit 0), a pin's status bit is 1 exactly while the pin is enabled and its filtered value equals its polarity bit (polarity 1 means high is active, 0 means low is active). The status follows the pin in the same cycle and holds no memory.
- R4: In edge mode (mode bit 1), an enabled pin latches a pending event on a rising edge of the filtered value when polarity is 1, and on a falling edge when polarity is 0. The edge is taken against the value of the previous cycle. The status is visible after the clock edge that samples the change. The event stays pending after the pin returns to its old level.
- R5: Writing the acknowledge register clears the pending event of each pin whose data bit is 1. Bits written as 0 leave their events pending.
- R6: If a qualifying edge and an acknowledge of the same pin happen in the same cycle, the event stays pending.
- R7: A pin whose enable bit is 0 shows status 0 and latches no edge event. Enabling it later does not reveal an edge that occurred while it was disabled.
- R8: With the pin's filter bit set, a new input level reaches detection only after it has been held for 4 consecutive clock cycles. A level held for 3 cycles or fewer is ignored.
- R9: `irq_ab` is 1 exactly when any status bit of port A or port B is 1. `irq_f[i]` equals status bit i of port F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data, one bit per pin |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_a | input | 8 | Synchronised port A pins |
| pin_b | input | 8 | Synchronised port B pins |
| pin_f | input | 8 | Synchronised port F pins |
| irq_ab | output | 1 | Combined request for ports A and B |
| irq_f | output | 8 | One request per port F pin |

## Verification
The bench lowers a pin and raises it again in the same cycle as an acknowledge write. A design that gives the acknowledge priority would lose that event, and the status bit would read 0. It acknowledges with patterns that leave the target bit at 0, which catches an acknowledge that clears a whole port. It toggles a pin while the pin is disabled and then enables it, which exposes an edge latch that ignores the enable. It holds a filtered pin for exactly three cycles and then exactly four, which shows a filter counter that is one cycle off in either direction. It checks each port F line on its own, so a swapped bit or a merged line shows up.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 8;

    // Register byte addresses of one port.
    typedef struct packed {
        logic [ADDR_W-1:0] mode;
        logic [ADDR_W-1:0] pol;
        logic [ADDR_W-1:0] ack;
        logic [ADDR_W-1:0] ena;
        logic [ADDR_W-1:0] filt;
        logic [ADDR_W-1:0] stat;
    } reg_map_t;

    localparam reg_map_t MAP_A = '{mode: 8'h90, pol: 8'h94, ack: 8'h98,
                                   ena: 8'h9C, filt: 8'hA8, stat: 8'hA0};
    localparam reg_map_t MAP_B = '{mode: 8'hAC, pol: 8'hB0, ack: 8'hB4,
                                   ena: 8'hB8, filt: 8'hC4, stat: 8'hBC};
    localparam reg_map_t MAP_F = '{mode: 8'h4C, pol: 8'h50, ack: 8'h54,
                                   ena: 8'h58, filt: 8'h64, stat: 8'h5C};

    localparam int NUM_PORTS = 3;

    function automatic reg_map_t port_map(input int idx);
        case (idx)
            0:       return MAP_A;
            1:       return MAP_B;
            default: return MAP_F;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
    parameter int STABLE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt,
    output logic at_limit
);
    localparam int CW = $clog2(STABLE + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STABLE - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } db_state_t;

    db_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LIMIT) begin
            st_d.lvl = raw;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign filt     = st_q.lvl;
    assign at_limit = (st_q.cnt == LIMIT) && (raw != st_q.lvl);

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int       PINS      = 8,
    parameter int       DB_STABLE = 4,
    parameter reg_map_t MAP       = MAP_A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pins,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    output logic [PINS-1:0]   rdata,
    output logic [PINS-1:0]   stat
);
    typedef struct packed {
        logic [PINS-1:0] mode;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] ena;
        logic [PINS-1:0] filt;
        logic [PINS-1:0] pend;
        logic [PINS-1:0] prev;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [PINS-1:0] db_val;
    logic [PINS-1:0] db_limit;
    logic [PINS-1:0] sel_val;
    logic [PINS-1:0] ack_mask;
    logic [PINS-1:0] edge_hit;
    logic [PINS-1:0] pend_vec;
    logic [PINS-1:0] ena_vec;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        gpio_irq_debounce #(.STABLE(DB_STABLE)) u_db (
            .clk      (clk),
            .rst      (rst),
            .raw      (pins[i]),
            .filt     (db_val[i]),
            .at_limit (db_limit[i])
        );
        assign sel_val[i] = st_q.filt[i] ? db_val[i] : pins[i];
    end

    always_comb begin
        logic [PINS-1:0] rise;
        logic [PINS-1:0] fall;
        logic [PINS-1:0] lvl_hit;

        st_d     = st_q;
        ack_mask = (wr_en && addr == MAP.ack) ? wdata : '0;

        rise     = sel_val & ~st_q.prev;
        fall     = ~sel_val & st_q.prev;
        edge_hit = st_q.mode & st_q.ena & ((st_q.pol & rise) | (~st_q.pol & fall));

        st_d.prev = sel_val;
        st_d.pend = edge_hit | (st_q.pend & ~ack_mask);

        if (wr_en) begin
            if (addr == MAP.mode) st_d.mode = wdata;
            if (addr == MAP.pol)  st_d.pol  = wdata;
            if (addr == MAP.ena)  st_d.ena  = wdata;
            if (addr == MAP.filt) st_d.filt = wdata;
        end

        lvl_hit = ~st_q.mode & ~(sel_val ^ st_q.pol);
        stat    = st_q.ena & (lvl_hit | (st_q.mode & st_q.pend));

        rdata = '0;
        if (addr == MAP.mode) rdata = st_q.mode;
        if (addr == MAP.pol)  rdata = st_q.pol;
        if (addr == MAP.ena)  rdata = st_q.ena;
        if (addr == MAP.filt) rdata = st_q.filt;
        if (addr == MAP.stat) rdata = stat;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_vec = st_q.pend;
    assign ena_vec  = st_q.ena;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int PINS      = 8,
    parameter int DB_STABLE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_a,
    input  logic [PINS-1:0]   pin_b,
    input  logic [PINS-1:0]   pin_f,
    output logic              irq_ab,
    output logic [PINS-1:0]   irq_f
);
    logic [NUM_PORTS-1:0][PINS-1:0] port_pins;
    logic [NUM_PORTS-1:0][PINS-1:0] port_rdata;
    logic [NUM_PORTS-1:0][PINS-1:0] port_stat;

    assign port_pins[0] = pin_a;
    assign port_pins[1] = pin_b;
    assign port_pins[2] = pin_f;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam reg_map_t PMAP = port_map(p);
        gpio_irq_port #(
            .PINS      (PINS),
            .DB_STABLE (DB_STABLE),
            .MAP       (PMAP)
        ) u_port (
            .clk   (clk),
            .rst   (rst),
            .pins  (port_pins[p]),
            .wr_en (bus_we),
            .addr  (bus_addr),
            .wdata (bus_wdata),
            .rdata (port_rdata[p]),
            .stat  (port_stat[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) bus_rdata = bus_rdata | port_rdata[p];
        irq_ab = |(port_stat[0] | port_stat[1]);
        irq_f  = port_stat[2];
    end

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_port_chk #(
    parameter int PINS = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [PINS-1:0] pend,
    input logic [PINS-1:0] ack,
    input logic [PINS-1:0] edge_hit,
    input logic [PINS-1:0] ena
);
    // R5: an acknowledged pin with no new edge is clear in the next cycle
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack != '0) |=> ((pend & $past(ack) & ~$past(edge_hit)) == '0));

    // R6: a fresh edge is pending in the next cycle, even if acknowledged
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (edge_hit != '0) |=> ((pend & $past(edge_hit)) == $past(edge_hit)));

    // R4: a pending event disappears only through an acknowledge
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |=> ((~pend & $past(pend) & ~$past(ack)) == '0));

    // R7: no event becomes pending on a pin that was disabled
    a_r7_no_latch_off: assert property (@(posedge clk) disable iff (rst)
        (ena != {PINS{1'b1}}) |=> ((pend & ~$past(pend) & ~$past(ena)) == '0));
endmodule

module gpio_irq_db_chk (
    input logic clk,
    input logic rst,
    input logic raw,
    input logic filt,
    input logic at_limit
);
    // R8: the filtered level moves only after the full hold time, and only to the input level
    a_r8_filter_hold: assert property (@(posedge clk) disable iff (rst)
        (filt != $past(filt)) |-> ($past(at_limit) && filt == $past(raw)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS)) u_port_chk (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend_vec),
    .ack      (ack_mask),
    .edge_hit (edge_hit),
    .ena      (ena_vec)
);

bind gpio_irq_debounce gpio_irq_db_chk u_db_chk (
    .clk      (clk),
    .rst      (rst),
    .raw      (raw),
    .filt     (filt),
    .at_limit (at_limit)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_a = '0;
    logic [7:0] pin_b = '0;
    logic [7:0] pin_f = '0;
    logic       irq_ab;
    logic [7:0] irq_f;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_a(pin_a),
        .pin_b(pin_b), .pin_f(pin_f), .irq_ab(irq_ab), .irq_f(irq_f)
    );

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        pin_a = '0; pin_b = '0; pin_f = '0; bus_we = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        logic [7:0] addrs [18] = '{8'h90, 8'h94, 8'h98, 8'h9C, 8'hA8, 8'hA0,
                                   8'hAC, 8'hB0, 8'hB4, 8'hB8, 8'hC4, 8'hBC,
                                   8'h4C, 8'h50, 8'h54, 8'h58, 8'h64, 8'h5C};
        do_reset();
        for (int i = 0; i < 18; i++) begin
            rd(addrs[i], v);
            chk("R1", $sformatf("reg %0h after reset", addrs[i]), v, 0);
        end
        chk("R1", "irq_ab after reset", irq_ab, 0);
        chk("R1", "irq_f after reset", irq_f, 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        do_reset();
        wr(8'h90, 8'h5A); wr(8'hB0, 8'hC3); wr(8'h64, 8'h81); wr(8'hA8, 8'h3C);
        rd(8'h90, v); chk("R2", "A mode readback", v, 8'h5A);
        rd(8'hB0, v); chk("R2", "B polarity readback", v, 8'hC3);
        rd(8'h64, v); chk("R2", "F filter readback", v, 8'h81);
        rd(8'hA8, v); chk("R2", "A filter readback", v, 8'h3C);
        rd(8'h94, v); chk("R2", "A polarity untouched", v, 8'h00);
        wr(8'h98, 8'hFF);
        rd(8'h98, v); chk("R2", "ack reads zero", v, 8'h00);
        wr(8'hBC, 8'hFF);
        rd(8'hBC, v); chk("R2", "status write ignored", v, 8'h00);
        chk("R2", "irq_ab after status write", irq_ab, 0);
    endtask

    task automatic t_level();
        logic [7:0] v;
        do_reset();
        wr(8'h9C, 8'h01);
        rd(8'hA0, v); chk("R3", "active-low level pin low", v, 8'h01);
        chk("R9", "irq_ab from port A", irq_ab, 1);
        wr(8'h94, 8'h01);
        rd(8'hA0, v); chk("R3", "active-high level pin low", v, 8'h00);
        pin_a[0] = 1'b1;
        rd(8'hA0, v); chk("R3", "level follows pin same cycle", v, 8'h01);
        pin_a[0] = 1'b0;
        rd(8'hA0, v); chk("R3", "level has no memory", v, 8'h00);
        chk("R9", "irq_ab drops", irq_ab, 0);
    endtask

    task automatic t_edge();
        logic [7:0] v;
        do_reset();
        wr(8'h4C, 8'h48); wr(8'h50, 8'h08); wr(8'h58, 8'h48);
        pin_f[3] = 1'b1;
        rd(8'h5C, v); chk("R4", "rise not yet sampled", v, 8'h00);
        step();
        rd(8'h5C, v); chk("R4", "rising edge latched", v, 8'h08);
        chk("R9", "irq_f bit 3 only", irq_f, 8'h08);
        pin_f[3] = 1'b0; step(2);
        rd(8'h5C, v); chk("R4", "event sticky after pin falls", v, 8'h08);
        pin_f[6] = 1'b1; step();
        rd(8'h5C, v); chk("R4", "rise ignored for falling pin", v, 8'h08);
        pin_f[6] = 1'b0; step();
        rd(8'h5C, v); chk("R4", "falling edge latched", v, 8'h48);
        chk("R9", "irq_f bits 3 and 6", irq_f, 8'h48);
    endtask

    task automatic t_ack();
        logic [7:0] v;
        do_reset();
        wr(8'h4C, 8'h08); wr(8'h50, 8'h08); wr(8'h58, 8'h08);
        pin_f[3] = 1'b1; step();
        wr(8'h54, 8'h00);
        rd(8'h5C, v); chk("R5", "ack of zero keeps event", v, 8'h08);
        wr(8'h54, 8'hF7);
        rd(8'h5C, v); chk("R5", "ack of other bits keeps event", v, 8'h08);
        wr(8'h54, 8'h08);
        rd(8'h5C, v); chk("R5", "ack clears event", v, 8'h00);
        chk("R5", "irq_f low after ack", irq_f, 8'h00);
    endtask

    task automatic t_edge_wins();
        logic [7:0] v;
        do_reset();
        wr(8'h4C, 8'h01); wr(8'h50, 8'h01); wr(8'h58, 8'h01);
        pin_f[0] = 1'b1; step();
        pin_f[0] = 1'b0; step();
        pin_f[0] = 1'b1;
        wr(8'h54, 8'h01);
        rd(8'h5C, v); chk("R6", "edge beats same-cycle ack", v, 8'h01);
        wr(8'h54, 8'h01);
        rd(8'h5C, v); chk("R6", "later ack clears", v, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        do_reset();
        wr(8'hAC, 8'h02); wr(8'hB0, 8'h02);
        pin_b[1] = 1'b1; step();
        rd(8'hBC, v); chk("R7", "disabled pin status", v, 8'h00);
        chk("R7", "irq_ab with disabled pin", irq_ab, 0);
        wr(8'hB8, 8'h02);
        rd(8'hBC, v); chk("R7", "no stale event on enable", v, 8'h00);
        pin_b[1] = 1'b0; step();
        pin_b[1] = 1'b1; step();
        rd(8'hBC, v); chk("R7", "edge after enable latched", v, 8'h02);
        chk("R9", "irq_ab from port B", irq_ab, 1);
    endtask

    task automatic t_filter();
        logic [7:0] v;
        do_reset();
        wr(8'hC4, 8'h04); wr(8'hB0, 8'h04); wr(8'hB8, 8'h04);
        pin_b[2] = 1'b1;
        step(3);
        rd(8'hBC, v); chk("R8", "level held 3 cycles blocked", v, 8'h00);
        step();
        rd(8'hBC, v); chk("R8", "level held 4 cycles passes", v, 8'h04);
        pin_b[2] = 1'b0; step(3);
        pin_b[2] = 1'b1;
        rd(8'hBC, v); chk("R8", "3-cycle dip ignored", v, 8'h04);
        step(4);
        rd(8'hBC, v); chk("R8", "dip never reached detection", v, 8'h04);
        wr(8'hC4, 8'h00);
        pin_b[2] = 1'b0;
        rd(8'hBC, v); chk("R8", "unfiltered pin follows at once", v, 8'h00);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_level();
        t_edge();
        t_ack();
        t_edge_wins();
        t_disabled();
        t_filter();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule